// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block divides a serial bit stream, one bit per clock, by a generator polynomial using a shift-register divider. The generator is set by parameters: `CRC_W` gives the degree n and `POLY` gives the n low coefficients. The leading coefficient is always 1 and is implied. All arithmetic is modulo 2, so each subtraction step is a plain XOR.

Each message begins with a start strobe. The start strobe samples the operating mode. In generate mode the block takes in the message bits. When the last bit has been accepted, it shifts the n-bit remainder out serially so that a transmitter can append it to the message as the frame check sequence. In check mode the whole received frame (message followed by its check bits) runs through the same divider. One cycle after the last bit a done strobe marks the result, and an error flag is set when the remainder is nonzero.

Top module: `crc_serial_engine`

## Requirements
- R1: While reset is asserted and after it is released, `fcs_vld`, `done` and `crc_err` are 0 and `rem` is all zeros until the first start strobe.
- R2: A `sop` pulse clears the remainder register to zero. A bit presented with `bit_vld` in the same cycle as `sop` is taken as the first message bit. A `sop` with no bit leaves `rem` at zero on the next cycle.
- R3: Accepted bits enter most significant first. Once the last message bit has been taken in generate mode, `rem` equals the remainder of the message times x^n divided by the generator 1·x^n + POLY.
- R4: In generate mode (`mode_chk`=0 at `sop`), the cycle after the bit flagged with `eom` starts exactly `CRC_W` consecutive cycles with `fcs_vld`=1, and `fcs_bit` carries the remainder MSB first. For message 1101011011 and generator 10011 the sequence is 1110.
- R5: While check bits are being shifted out, `bit_vld`/`bit_dat` have no effect, and `rem` shifts left by one with a zero filled in at the bottom each cycle.
- R6: In check mode (`mode_chk`=1 at `sop`), `done` is high for the one cycle after the `eom` bit. `crc_err` is then 1 exactly when the full-frame remainder is nonzero, and it holds that value until the next `sop`.
- R7: In generate mode `crc_err` stays 0, and `done` pulses in the cycle after the last check bit.
- R8: Outside a message (after the end of a frame and before the next `sop`), `bit_vld` is ignored and `rem` keeps its value.
- R9: A `sop` arriving during check-bit output abandons it: on the next cycle `fcs_vld` is 0 and no `done` follows for the abandoned frame.
- R10: A parameter selects the generator. Both x^16+x^15+x^2+1 (`POLY`=16'h8005) and x^16+x^12+x^5+1 (`POLY`=16'h1021) work at `CRC_W`=16, as do smaller degrees such as 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_chk | input | 1 | Mode sampled at `sop`: 0 generate, 1 check |
| sop | input | 1 | Start of message strobe |
| eom | input | 1 | Marks the accepted bit as the last of the message/frame |
| bit_vld | input | 1 | Serial input bit is valid |
| bit_dat | input | 1 | Serial input bit |
| fcs_bit | output | 1 | Serial check-sequence bit, MSB first |
| fcs_vld | output | 1 | `fcs_bit` is valid |
| rem | output | CRC_W | Current remainder register |
| crc_err | output | 1 | Check mode: nonzero remainder at end of frame |
| done | output | 1 | One-cycle end-of-operation strobe |

## Verification
On every cycle the assertions check the following. The check-bit run never exceeds `CRC_W` cycles and ends on time. During output the register only shifts with zero fill. Idle cycles leave the remainder unchanged. A lone start strobe zeroes it. The error flag is never raised in generate mode and is only ever high over a nonzero remainder. Whether the remainder and the check bits hold the correct values for a given generator, and whether good and corrupted frames are classified correctly, can only be shown by the bench's scenarios. The bench compares against its own long division, applied to several messages and to three generators of two widths.

// File: rtl/crc_pkg.sv
package crc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MSG  = 2'd1,
    ST_FCS  = 2'd2
  } crc_state_e;

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;

endmodule

// File: rtl/crc_div_step.sv
// One step of modulo-2 division: shift left, and XOR the generator
// taps in when the feedback bit is set and feedback is enabled.
module crc_div_step #(
  parameter int                CRC_W = 16,
  parameter logic [CRC_W-1:0]  POLY  = 16'h8005
) (
  input  logic [CRC_W-1:0] cur,
  input  logic             din,
  input  logic             fb_en,
  output logic [CRC_W-1:0] nxt
);

  logic fb;

  assign fb = fb_en & (cur[CRC_W-1] ^ din);

  generate
    for (genvar i = 0; i < CRC_W; i++) begin : g_tap
      if (i == 0) begin : g_lsb
        if (POLY[0]) begin : g_on
          assign nxt[0] = fb;
        end else begin : g_off
          assign nxt[0] = 1'b0;
        end
      end else begin : g_up
        if (POLY[i]) begin : g_on
          assign nxt[i] = cur[i-1] ^ fb;
        end else begin : g_off
          assign nxt[i] = cur[i-1];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crc_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_chk,
  input  logic       sop,
  input  logic       eom,
  input  logic       bit_vld,
  output crc_state_e state,
  output logic       shift_en,
  output logic       fb_en,
  output logic       chk_end,
  output logic       done_n
);

  localparam int CNT_W = (CRC_W > 1) ? $clog2(CRC_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CRC_W - 1);

  crc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             mode_q;
  logic             mode_eff;
  logic             accept;
  logic             ending;
  logic             fcs_last;

  assign mode_eff = sop ? mode_chk : mode_q;
  assign accept   = bit_vld & (sop | (state_q == ST_MSG));
  assign ending   = accept & eom;
  assign fcs_last = (state_q == ST_FCS) & ~sop & (cnt_q == CNT_LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (sop) begin
      cnt_d   = '0;
      state_d = ST_MSG;
      if (ending) state_d = mode_chk ? ST_IDLE : ST_FCS;
    end else begin
      case (state_q)
        ST_MSG: begin
          if (ending) begin
            state_d = mode_q ? ST_IDLE : ST_FCS;
            cnt_d   = '0;
          end
        end
        ST_FCS: begin
          if (cnt_q == CNT_LAST) state_d = ST_IDLE;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (sop) mode_q <= mode_chk;
    end
  end

  assign state    = state_q;
  assign fb_en    = accept;
  assign shift_en = accept | ((state_q == ST_FCS) & ~sop);
  assign chk_end  = ending & mode_eff;
  assign done_n   = chk_end | fcs_last;

endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine
  import crc_pkg::*;
#(
  parameter int               CRC_W = 16,
  parameter logic [CRC_W-1:0] POLY  = 16'h8005
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_chk,
  input  logic             sop,
  input  logic             eom,
  input  logic             bit_vld,
  input  logic             bit_dat,
  output logic             fcs_bit,
  output logic             fcs_vld,
  output logic [CRC_W-1:0] rem,
  output logic             crc_err,
  output logic             done
);

  logic             rst_int_n;
  crc_state_e       state_s;
  logic             shift_en;
  logic             fb_en;
  logic             chk_end;
  logic             done_n;
  logic [CRC_W-1:0] crc_q, crc_d;
  logic [CRC_W-1:0] base;
  logic [CRC_W-1:0] step_out;
  logic             err_q, err_d;
  logic             done_q;

  crc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  crc_ctrl #(.CRC_W(CRC_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .mode_chk (mode_chk),
    .sop      (sop),
    .eom      (eom),
    .bit_vld  (bit_vld),
    .state    (state_s),
    .shift_en (shift_en),
    .fb_en    (fb_en),
    .chk_end  (chk_end),
    .done_n   (done_n)
  );

  assign base = sop ? '0 : crc_q;

  crc_div_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
    .cur   (base),
    .din   (bit_dat),
    .fb_en (fb_en),
    .nxt   (step_out)
  );

  always_comb begin
    crc_d = base;
    if (shift_en) crc_d = step_out;
  end

  always_comb begin
    err_d = err_q;
    if (sop)     err_d = 1'b0;
    if (chk_end) err_d = |step_out;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      crc_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      err_q  <= err_d;
      done_q <= done_n;
    end
  end

  assign fcs_vld = (state_s == ST_FCS);
  assign fcs_bit = fcs_vld & crc_q[CRC_W-1];
  assign rem     = crc_q;
  assign crc_err = err_q;
  assign done    = done_q;

endmodule

// File: rtl/crc_serial_chk.sv
module crc_serial_chk
  import crc_pkg::*;
#(
  parameter int CRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sop,
  input logic             fcs_vld,
  input logic [CRC_W-1:0] rem,
  input logic             crc_err,
  input logic             bit_vld,
  input crc_state_e       state_s
);

  localparam int RUN_W = $clog2(CRC_W + 1) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= (fcs_vld && !sop) ? run_q + 1'b1 : '0;
  end

  a_r4_fcs_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_vld |-> (run_q < RUN_W'(CRC_W)));

  a_r4_fcs_run_end: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_vld && !sop && run_q == RUN_W'(CRC_W - 1)) |=> !fcs_vld);

  a_r5_fcs_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fcs_vld && !sop) |=> (rem == ($past(rem) << 1)));

  a_r7_gen_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_vld |-> !crc_err);

  a_r6_err_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> (rem != '0));

  a_r2_sop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (sop && !bit_vld) |=> (rem == '0));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_s == ST_IDLE && !sop) |=> $stable(rem));

endmodule

bind crc_serial_engine crc_serial_chk #(.CRC_W(CRC_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sop     (sop),
  .fcs_vld (fcs_vld),
  .rem     (rem),
  .crc_err (crc_err),
  .bit_vld (bit_vld),
  .state_s (state_s)
);

// File: tb/test_crc_serial_engine.sv
module test_crc_serial_engine;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    bit    is_done;
    bit    val;
    string req;
  } exp_item_t;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_chk, sop, eom, bit_vld, bit_dat;

  logic fv[3], fb[3], dn[3], er[3];
  logic [15:0] rem_a, rem_c;
  logic [3:0]  rem_b;

  int checks = 0;
  int fails  = 0;
  bit sb_on  = 1'b0;
  int cyc    = 0;

  exp_item_t q0[$], q1[$], q2[$];

  int          wid[3] = '{16, 4, 16};
  logic [15:0] pl[3]  = '{16'h8005, 16'h0003, 16'h1021};

  always #(CLK_PERIOD/2) clk = ~clk;

  crc_serial_engine #(.CRC_W(16), .POLY(16'h8005)) i_crc_serial_engine (
    .clk(clk), .rst_n(rst_n), .mode_chk(mode_chk), .sop(sop), .eom(eom),
    .bit_vld(bit_vld), .bit_dat(bit_dat), .fcs_bit(fb[0]), .fcs_vld(fv[0]),
    .rem(rem_a), .crc_err(er[0]), .done(dn[0]));

  crc_serial_engine #(.CRC_W(4), .POLY(4'h3)) i_crc_serial_engine_w4 (
    .clk(clk), .rst_n(rst_n), .mode_chk(mode_chk), .sop(sop), .eom(eom),
    .bit_vld(bit_vld), .bit_dat(bit_dat), .fcs_bit(fb[1]), .fcs_vld(fv[1]),
    .rem(rem_b), .crc_err(er[1]), .done(dn[1]));

  crc_serial_engine #(.CRC_W(16), .POLY(16'h1021)) i_crc_serial_engine_ccitt (
    .clk(clk), .rst_n(rst_n), .mode_chk(mode_chk), .sop(sop), .eom(eom),
    .bit_vld(bit_vld), .bit_dat(bit_dat), .fcs_bit(fb[2]), .fcs_vld(fv[2]),
    .rem(rem_c), .crc_err(er[2]), .done(dn[2]));

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: long division of m * x^w by the generator, bit array form.
  function automatic logic [15:0] ref_rem(int w, logic [15:0] p, bit m[$]);
    bit a[$];
    logic [15:0] r = '0;
    a = m;
    for (int i = 0; i < w; i++) a.push_back(1'b0);
    for (int i = 0; i < m.size(); i++) begin
      if (a[i]) begin
        a[i] = 1'b0;
        for (int j = 1; j <= w; j++) a[i+j] = a[i+j] ^ p[w-j];
      end
    end
    for (int j = 0; j < w; j++) r[w-1-j] = a[m.size()+j];
    return r;
  endfunction

  task automatic push(int k, exp_item_t it);
    if (k == 0) q0.push_back(it);
    else if (k == 1) q1.push_back(it);
    else q2.push_back(it);
  endtask

  task automatic mon(int k);
    exp_item_t it;
    int sz;
    sz = (k == 0) ? q0.size() : (k == 1) ? q1.size() : q2.size();
    if (fv[k] || dn[k]) begin
      if (sz == 0) begin
        check(1'b0, "R4", $sformatf("unexpected output inst %0d", k), {fv[k], dn[k]}, 0);
      end else begin
        if (k == 0) it = q0.pop_front();
        else if (k == 1) it = q1.pop_front();
        else it = q2.pop_front();
        if (it.is_done)
          check(dn[k] && !fv[k] && er[k] == it.val, it.req,
                $sformatf("done/crc_err inst %0d", k), {dn[k], er[k]}, {1'b1, it.val});
        else
          check(fv[k] && !dn[k] && fb[k] == it.val, it.req,
                $sformatf("fcs bit inst %0d", k), {fv[k], fb[k]}, {1'b1, it.val});
      end
    end
  endtask

  always @(negedge clk) begin
    if (sb_on && rst_n) begin
      for (int k = 0; k < 3; k++) mon(k);
    end
  end

  task automatic drive(bit chk, bit m[$]);
    for (int i = 0; i < m.size(); i++) begin
      sop      = (i == 0);
      mode_chk = chk;
      bit_vld  = 1'b1;
      bit_dat  = m[i];
      eom      = (i == m.size() - 1);
      @(negedge clk);
    end
    sop = 1'b0; eom = 1'b0; bit_vld = 1'b0; bit_dat = 1'b0;
  endtask

  // Scoreboard driver: push expected outputs, then drive the frame.
  task automatic send(bit chk, bit m[$], bit noisy);
    logic [15:0] r;
    exp_item_t it;
    for (int k = 0; k < 3; k++) begin
      r = ref_rem(wid[k], pl[k], m);
      if (!chk) begin
        for (int j = wid[k] - 1; j >= 0; j--) begin
          it.is_done = 1'b0; it.val = r[j]; it.req = noisy ? "R5" : "R4";
          push(k, it);
        end
        it.is_done = 1'b1; it.val = 1'b0; it.req = "R7";
        push(k, it);
      end else begin
        it.is_done = 1'b1; it.val = (r != 0); it.req = "R6";
        push(k, it);
      end
    end
    drive(chk, m);
    if (!chk) begin
      check(rem_a == ref_rem(16, pl[0], m), "R3", "rem after message 8005", rem_a, ref_rem(16, pl[0], m));
      check(rem_b == ref_rem(4, pl[1], m)[3:0], "R3", "rem after message w4", rem_b, ref_rem(4, pl[1], m));
      check(rem_c == ref_rem(16, pl[2], m), "R10", "rem after message 1021", rem_c, ref_rem(16, pl[2], m));
    end
    for (int i = 0; i < 20; i++) begin
      bit_vld = noisy;
      bit_dat = noisy ? 1'($urandom_range(1)) : 1'b0;
      @(negedge clk);
    end
    bit_vld = 1'b0; bit_dat = 1'b0;
  endtask

  function automatic void append_fcs(ref bit f[$], input int w, input logic [15:0] r);
    for (int j = w - 1; j >= 0; j--) f.push_back(r[j]);
  endfunction

  initial begin
    bit m1[$], m2[$], m3[$], f[$];
    logic [15:0] hold;
    rst_n = 1'b0; mode_chk = 1'b0; sop = 1'b0; eom = 1'b0; bit_vld = 1'b0; bit_dat = 1'b0;
    m1 = '{1,1,0,1,0,1,1,0,1,1};
    m2 = '{1,1,0,0,1,1};
    for (int i = 0; i < 40; i++) m3.push_back(1'($urandom_range(1)));
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++)
      check(!fv[k] && !dn[k] && !er[k], "R1", $sformatf("outputs in reset inst %0d", k), {fv[k], dn[k], er[k]}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rem_a == 0 && rem_b == 0 && !fv[0] && !dn[0] && !er[0], "R1", "state after reset", rem_a, 0);
    sb_on = 1'b1;

    // Generate: worked example, then explicit FCS value on the width-4 instance
    drive(1'b0, m1);
    check(rem_b == 4'hE, "R4", "example check sequence 1110", rem_b, 4'hE);
    sb_on = 1'b0;
    repeat (20) @(negedge clk);
    check(!fv[0] && !fv[1] && !fv[2], "R4", "fcs run finished", {fv[0], fv[1], fv[2]}, 0);
    sb_on = 1'b1;

    send(1'b0, m1, 1'b0);
    send(1'b0, m2, 1'b1);
    send(1'b0, m3, 1'b1);

    // Check mode: good frame for the width-4 generator, then corrupted
    f = m1; append_fcs(f, 4, 16'hE);
    send(1'b1, f, 1'b1);
    check(er[1] == 1'b0, "R6", "good w4 frame flag held", er[1], 0);
    f[3] = ~f[3];
    send(1'b1, f, 1'b0);
    check(er[1] == 1'b1, "R6", "corrupted w4 frame flag held", er[1], 1);

    // Check mode: frame built for 8005, and one built for 1021
    f = m3; append_fcs(f, 16, ref_rem(16, 16'h8005, m3));
    send(1'b1, f, 1'b0);
    check(er[0] == 1'b0, "R10", "good 8005 frame", er[0], 0);
    f = m3; append_fcs(f, 16, ref_rem(16, 16'h1021, m3));
    send(1'b1, f, 1'b0);
    check(er[2] == 1'b0, "R10", "good 1021 frame", er[2], 0);

    // Idle bits are ignored
    hold = rem_a;
    bit_vld = 1'b1;
    for (int i = 0; i < 6; i++) begin
      bit_dat = ~bit_dat;
      @(negedge clk);
    end
    bit_vld = 1'b0;
    check(rem_a == hold, "R8", "rem unchanged by idle bits", rem_a, hold);

    // Lone sop clears the register
    sop = 1'b1; mode_chk = 1'b1;
    @(negedge clk);
    sop = 1'b0;
    check(rem_a == 0 && er[0] == 0, "R2", "sop clears rem and flag", rem_a, 0);
    sb_on = 1'b0;
    repeat (2) @(negedge clk);

    // Abort during FCS output
    drive(1'b0, m3);
    repeat (2) @(negedge clk);
    check(fv[0] == 1'b1, "R9", "fcs running before abort", fv[0], 1);
    sop = 1'b1;
    @(negedge clk);
    sop = 1'b0;
    check(fv[0] == 1'b0 && rem_a == 0, "R9", "fcs abandoned on sop", {fv[0], rem_a}, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dn[0] || fv[0]) check(1'b0, "R9", "output after abort", {dn[0], fv[0]}, 0);
    end
    checks++;
    sb_on = 1'b1;

    // Sop with first bit in the same cycle, single-bit check frame
    sop = 1'b1; mode_chk = 1'b1; bit_vld = 1'b1; bit_dat = 1'b1; eom = 1'b1;
    begin
      exp_item_t it;
      it.is_done = 1'b1; it.val = 1'b1; it.req = "R2";
      for (int k = 0; k < 3; k++) push(k, it);
    end
    @(negedge clk);
    sop = 1'b0; bit_vld = 1'b0; eom = 1'b0; bit_dat = 1'b0;
    repeat (4) @(negedge clk);

    check(q0.size() == 0 && q1.size() == 0 && q2.size() == 0, "R4",
          "all expected outputs seen", q0.size() + q1.size() + q2.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog expired: actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule